// File: doc/BRIEF.md
# Partitioned Set Tag Lookup with Superpage Filtering

This block is the tag and replacement control of a first-level cache that is indexed with virtual address bits and tagged with physical address bits. Every set holds eight ways, split into two halves of four ways each. A request carries a set index, a partition-select bit, a superpage hint and the physical tag delivered by the translation lookaside buffer. The partition-select bit comes from an address bit that lies above the 4 KB page offset but below bit 21. For a superpage that bit is untranslated, so it can pick a half of the set before the translation is done.

When the hint says superpage, a lookup compares the tag against only the four ways of the selected half. That reads fewer tags per lookup. When the hint says basepage, all eight ways are compared. A fill request installs a line. Before allocating, it compares the tag against every way of the set. If the line is already present anywhere in the set, it is not installed a second time and the existing way is reported. Otherwise a victim is chosen. A superpage fill searches only the selected half. A basepage fill searches the whole set. Invalid ways take priority over the pseudo-LRU choice.

Valid bits, tags and replacement state are all held inside the block. Each request is answered one cycle after it is accepted. A request to the same set in the next cycle already sees the updated state.

Top module: `spc_tag_lookup`

## Requirements
- R1: After reset every way of every set is invalid. Every lookup then misses, and `rsp_valid` stays low until the first request.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low. The response fields are registered and change only with `rsp_valid`.
- R3: A basepage lookup (`req_super`=0, `req_fill`=0) hits when any of the eight ways of the set is valid and holds `req_tag`. It returns `rsp_hit`=1 and `rsp_way` set to that way (0..7).
- R4: A superpage lookup compares only ways 4p..4p+3, where p is `req_part`. A matching line in the other half gives `rsp_hit`=0.
- R5: A fill with no copy of the tag in the set allocates a way. A superpage fill allocates within ways 4p..4p+3 of the selected half p. A basepage fill may allocate any of ways 0..7. `rsp_way` returns the way written, and a later lookup of that tag hits there.
- R6: If the allowed range of a fill has an invalid way, the lowest-numbered invalid way in that range is the victim.
- R7: With no invalid way in range, the victim comes from pseudo-LRU state. Each set keeps a half bit H, and each half keeps a root bit A plus pair bits B (ways 0,1 of the half) and C (ways 2,3). The victim within a half is way 0 or 1 of the half, chosen by B, when A=0, and way 2 or 3, chosen by C, when A=1. A superpage fill uses half p. A basepage fill uses half H. A touch of way q of half h sets H=!h and A=(q<2). It also sets B=(q==0) when q<2, or C=(q==2) otherwise. All state bits are 0 after reset.
- R8: A fill whose tag is already valid in any way of the set, in either half, writes no tag or valid bit. It returns `rsp_dup`=1 and `rsp_way` set to the existing way, and touches that way.
- R9: The replacement state is touched by every lookup hit, every fill allocation and every duplicate fill. A lookup miss changes no state and returns in `rsp_way` the victim a fill would pick. State of one set is never altered by a request to another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_fill | input | 1 | 1 = fill, 0 = lookup |
| req_set | input | SET_W (6) | Virtual set index |
| req_part | input | 1 | Partition-select bit from the address bits above the base page offset |
| req_super | input | 1 | Superpage hint |
| req_tag | input | TAG_W (20) | Physical tag |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_dup | output | 1 | Fill found the line already present |
| rsp_way | output | 3 | Hit way, existing way, allocated way, or victim preview on a lookup miss |

## Verification
On a fill, the duplicate search over the whole set and the victim choice in the allowed range happen in the same cycle, and the duplicate must win. The bench provokes this in two ways. It installs a line with a basepage fill and then sends a superpage lookup and fill for the same tag through the other half. It also lets random fills land on tags already present in sets with free ways. Each response is judged against a reference model that keeps its own tags, valid bits and tree bits. The `rsp_dup` flag and the returned way must match the model, and later lookups must show that nothing was written over.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int HALF_WAYS = 4;
  localparam int SET_WAYS  = 2 * HALF_WAYS;
  localparam int WAY_W     = $clog2(SET_WAYS);

  typedef logic [WAY_W-1:0] way_t;
  // [6] half pointer, [5:3] tree of half 1, [2:0] tree of half 0
  typedef logic [6:0] tree_t;

  function automatic logic [1:0] half_pick(input logic [2:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  function automatic logic [2:0] half_touch(input logic [2:0] t, input logic [1:0] q);
    logic [2:0] r;
    r    = t;
    r[0] = ~q[1];
    if (!q[1]) r[1] = ~q[0];
    else       r[2] = ~q[0];
    return r;
  endfunction

  function automatic tree_t set_touch(input tree_t t, input way_t w);
    tree_t r;
    r    = t;
    r[6] = ~w[2];
    if (w[2]) r[5:3] = half_touch(t[5:3], w[1:0]);
    else      r[2:0] = half_touch(t[2:0], w[1:0]);
    return r;
  endfunction

  function automatic way_t lowest_one(input logic [SET_WAYS-1:0] v);
    way_t r;
    r = '0;
    for (int i = SET_WAYS - 1; i >= 0; i--)
      if (v[i]) r = i[WAY_W-1:0];
    return r;
  endfunction

  function automatic logic [SET_WAYS-1:0] range_mask(input logic sup, input logic part);
    if (!sup) return '1;
    return part ? {{HALF_WAYS{1'b1}}, {HALF_WAYS{1'b0}}}
                : {{HALF_WAYS{1'b0}}, {HALF_WAYS{1'b1}}};
  endfunction
endpackage

// File: rtl/spc_tag_compare.sv
module spc_tag_compare
  import spc_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                probe_en,
  input  logic [TAG_W-1:0]    probe_tag,
  input  logic [TAG_W-1:0]    way_tag [SET_WAYS],
  input  logic [SET_WAYS-1:0] way_valid,
  input  logic [SET_WAYS-1:0] probe_mask,
  output logic [SET_WAYS-1:0] match_all,
  output logic [SET_WAYS-1:0] match_probe
);
  for (genvar w = 0; w < SET_WAYS; w++) begin : g_way
    assign match_all[w] = way_valid[w] && (way_tag[w] == probe_tag);
  end
  assign match_probe = match_all & probe_mask;

  // R8: fills never create a second copy, so at most one way matches
  a_r8_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    probe_en |-> $onehot0(match_all));
endmodule

// File: rtl/spc_victim_pick.sv
module spc_victim_pick
  import spc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chk_en,
  input  logic [SET_WAYS-1:0] way_valid,
  input  tree_t               tree,
  input  logic                sup,
  input  logic                part,
  output way_t                victim,
  output logic                has_free
);
  logic [SET_WAYS-1:0] in_range;
  logic [SET_WAYS-1:0] free_vec;
  logic                use_half;
  logic [1:0]          lru_q;

  assign in_range = range_mask(sup, part);
  assign free_vec = ~way_valid & in_range;
  assign has_free = |free_vec;
  assign use_half = sup ? part : tree[6];
  assign lru_q    = half_pick(use_half ? tree[5:3] : tree[2:0]);

  always_comb begin
    if (has_free) victim = lowest_one(free_vec);
    else          victim = {use_half, lru_q};
  end

  // R5: superpage victim stays in the selected half
  a_r5_victim_in_half: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && sup) |-> (victim[2] == part));
  // R6: a free victim is never a valid way
  a_r6_free_is_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && has_free) |-> !way_valid[victim]);
endmodule

// File: rtl/spc_plru_store.sv
module spc_plru_store
  import spc_pkg::*;
#(
  parameter int SETS = 64,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output tree_t            rd_tree,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  way_t             upd_way
);
  tree_t tree_q [SETS];

  assign rd_tree = tree_q[rd_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd_en) begin
      tree_q[upd_set] <= set_touch(tree_q[upd_set], upd_way);
    end
  end

  // R7: after a touch the half pointer leaves the touched half
  a_r7_half_moves_away: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (tree_q[$past(upd_set)][6] != $past(upd_way[2])));
endmodule

// File: rtl/spc_tag_lookup.sv
module spc_tag_lookup
  import spc_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_fill,
  input  logic [SET_W-1:0] req_set,
  input  logic             req_part,
  input  logic             req_super,
  input  logic [TAG_W-1:0] req_tag,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_dup,
  output logic [2:0]       rsp_way
);
  logic [SET_WAYS-1:0] vld_q [SETS];
  logic [TAG_W-1:0]    tag_q [SETS][SET_WAYS];

  logic [TAG_W-1:0]    row_tag [SET_WAYS];
  logic [SET_WAYS-1:0] row_vld;
  logic [SET_WAYS-1:0] probe_mask;
  logic [SET_WAYS-1:0] match_all;
  logic [SET_WAYS-1:0] match_probe;
  tree_t               row_tree;
  way_t                victim_way;
  logic                victim_free;
  way_t                hit_way;
  way_t                dup_way;
  way_t                touch_way;
  way_t                next_way;

  // named internal events
  logic ev_lookup, ev_fill, ev_hit, ev_dup, ev_alloc, ev_touch;

  always_comb begin
    for (int w = 0; w < SET_WAYS; w++) row_tag[w] = tag_q[req_set][w];
  end
  assign row_vld    = vld_q[req_set];
  assign probe_mask = range_mask(req_super, req_part);

  spc_tag_compare #(.TAG_W(TAG_W)) i_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .probe_en    (req_valid),
    .probe_tag   (req_tag),
    .way_tag     (row_tag),
    .way_valid   (row_vld),
    .probe_mask  (probe_mask),
    .match_all   (match_all),
    .match_probe (match_probe)
  );

  spc_plru_store #(.SETS(SETS)) i_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_set  (req_set),
    .rd_tree (row_tree),
    .upd_en  (ev_touch),
    .upd_set (req_set),
    .upd_way (touch_way)
  );

  spc_victim_pick i_vic (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_en    (req_valid),
    .way_valid (row_vld),
    .tree      (row_tree),
    .sup       (req_super),
    .part      (req_part),
    .victim    (victim_way),
    .has_free  (victim_free)
  );

  assign hit_way   = lowest_one(match_probe);
  assign dup_way   = lowest_one(match_all);
  assign ev_lookup = req_valid && !req_fill;
  assign ev_fill   = req_valid && req_fill;
  assign ev_hit    = ev_lookup && (|match_probe);
  assign ev_dup    = ev_fill && (|match_all);
  assign ev_alloc  = ev_fill && !(|match_all);
  assign ev_touch  = ev_hit || ev_fill;

  always_comb begin
    if (ev_hit)      touch_way = hit_way;
    else if (ev_dup) touch_way = dup_way;
    else             touch_way = victim_way;
  end
  assign next_way = touch_way;

  // valid bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (ev_alloc) begin
      vld_q[req_set][victim_way] <= 1'b1;
    end
  end

  // tag storage, no reset needed behind the valid bits
  always_ff @(posedge clk) begin
    if (ev_alloc) tag_q[req_set][victim_way] <= req_tag;
  end

  // registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_dup   <= 1'b0;
      rsp_way   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit <= ev_hit;
        rsp_dup <= ev_dup;
        rsp_way <= next_way;
      end
    end
  end

  // R2: one response per request, none otherwise
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R4: a superpage hit lies in the selected half
  a_r4_hit_in_half: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && req_super) |=> (rsp_way[2] == $past(req_part)));
  // R5: an allocation leaves the chosen way valid
  a_r5_alloc_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |=> vld_q[$past(req_set)][$past(victim_way)]);
  // R8: a duplicate fill leaves the valid bits of the set unchanged
  a_r8_dup_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dup |=> (vld_q[$past(req_set)] == $past(row_vld)));
  // R3: hit and dup are never reported together
  a_r3_hit_dup_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_dup));
endmodule

// File: tb/test_spc_tag_lookup.sv
`timescale 1ns/1ps
module test_spc_tag_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_fill = 1'b0;
  logic [5:0]  req_set = '0;
  logic        req_part = 1'b0;
  logic        req_super = 1'b0;
  logic [19:0] req_tag = '0;
  logic        rsp_valid, rsp_hit, rsp_dup;
  logic [2:0]  rsp_way;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spc_tag_lookup i_spc_tag_lookup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fill(req_fill),
    .req_set(req_set), .req_part(req_part), .req_super(req_super), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dup(rsp_dup), .rsp_way(rsp_way)
  );

  // reference model
  bit       mv  [64][8];
  int       mt  [64][8];
  bit [6:0] mtr [64];

  bit [4:0] qe [$];
  string    ql [$];

  function automatic int ref_victim(int s, bit sup, bit p);
    int lo, hi, half, base;
    bit [2:0] t;
    lo = sup ? p * 4 : 0;
    hi = sup ? lo + 3 : 7;
    for (int w = lo; w <= hi; w++) if (!mv[s][w]) return w;
    half = sup ? int'(p) : int'(mtr[s][6]);
    base = half * 4;
    t = (half == 1) ? mtr[s][5:3] : mtr[s][2:0];
    if (!t[0]) return base + (t[1] ? 1 : 0);
    return base + 2 + (t[2] ? 1 : 0);
  endfunction

  task automatic ref_touch(int s, int w);
    int q, half;
    bit [2:0] t;
    q = w % 4;
    half = w / 4;
    t = (half == 1) ? mtr[s][5:3] : mtr[s][2:0];
    t[0] = (q < 2);
    if (q < 2) t[1] = (q == 0);
    else       t[2] = (q == 2);
    if (half == 1) mtr[s][5:3] = t; else mtr[s][2:0] = t;
    mtr[s][6] = (half == 0);
  endtask

  task automatic op(bit fill, int s, bit p, bit sup, int tag, string lbl = "");
    int found, fw, vw;
    bit e_hit, e_dup;
    int e_way;
    string l;
    @(negedge clk);
    req_valid = 1'b1; req_fill = fill; req_set = s[5:0];
    req_part = p; req_super = sup; req_tag = tag[19:0];
    found = 0; fw = 0;
    for (int w = 7; w >= 0; w--) begin
      if (mv[s][w] && mt[s][w] == tag && (fill || !sup || (w / 4) == int'(p))) begin
        found = 1; fw = w;
      end
    end
    e_hit = 0; e_dup = 0;
    if (!fill) begin
      l = sup ? "R4" : "R3";
      if (found) begin e_hit = 1; e_way = fw; ref_touch(s, fw); end
      else e_way = ref_victim(s, sup, p);
    end else if (found) begin
      l = "R8"; e_dup = 1; e_way = fw; ref_touch(s, fw);
    end else begin
      vw = ref_victim(s, sup, p);
      if (vw != ref_victim(s, sup, p)) l = "R7";
      begin
        bit free_in;
        free_in = 0;
        for (int w = 0; w < 8; w++)
          if (!mv[s][w] && (!sup || (w / 4) == int'(p))) free_in = 1;
        if (free_in) l = sup ? "R5 R6" : "R6";
        else         l = sup ? "R5 R7" : "R7";
      end
      e_way = vw; mv[s][vw] = 1; mt[s][vw] = tag; ref_touch(s, vw);
    end
    if (lbl != "") l = lbl;
    qe.push_back({e_hit, e_dup, e_way[2:0]});
    ql.push_back(l);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (started && !done) begin
      if (qe.size() > 0) begin
        bit [4:0] e;
        string l;
        e = qe.pop_front();
        l = ql.pop_front();
        total++;
        if (!rsp_valid || {rsp_hit, rsp_dup, rsp_way} != e) begin
          bad++;
          $display("FAIL %s: got v=%0b hit=%0b dup=%0b way=%0d, expected v=1 hit=%0b dup=%0b way=%0d",
                   l, rsp_valid, rsp_hit, rsp_dup, rsp_way, e[4], e[3], e[2:0]);
        end
      end else if (rsp_valid) begin
        total++; bad++;
        $display("FAIL R2: got rsp_valid=1 with no request, expected 0");
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 64; s++) begin
      mtr[s] = '0;
      for (int w = 0; w < 8; w++) begin mv[s][w] = 0; mt[s][w] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: got rsp_valid=%0b after reset, expected 0", rsp_valid);
    end
    started = 1;

    // R1: empty cache misses everywhere
    op(0, 5, 0, 0, 'h111, "R1");
    op(0, 63, 1, 1, 'h222, "R1");

    // R5 R6: basepage fills fill ways 0..7 in order
    for (int i = 0; i < 8; i++) op(1, 5, 0, 0, 'h100 + i);
    // R3: every way hits with basepage lookup
    for (int i = 0; i < 8; i++) op(0, 5, 0, 0, 'h100 + i);
    // R4: line in way 5 is invisible through half 0, visible through half 1
    op(0, 5, 0, 1, 'h105);
    op(0, 5, 1, 1, 'h105);
    // R8: superpage fill through the other half finds the existing copy
    op(1, 5, 0, 1, 'h106);
    op(0, 5, 0, 0, 'h106);
    // R7: full set, basepage replacement by tree
    op(1, 5, 0, 0, 'h200);
    op(1, 5, 1, 0, 'h201);
    op(0, 5, 0, 0, 'h200);
    // back-to-back fill then lookup in the same set
    op(1, 7, 1, 1, 'h300);
    op(0, 7, 1, 1, 'h300);
    // R5: superpage fills stay in half 1, then replace within it
    for (int i = 1; i < 7; i++) op(1, 7, 1, 1, 'h300 + i);
    op(0, 7, 0, 0, 'h301);
    // R9: other sets untouched
    op(0, 6, 0, 0, 'h100, "R9");
    op(0, 4, 1, 1, 'h105, "R9");
    idle(2);

    // mixed traffic with a small tag space to force duplicates
    for (int i = 0; i < 400; i++) begin
      op($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1),
         $urandom_range(0, 1), $urandom_range(1, 7));
      if ($urandom_range(0, 7) == 0) idle(1);
    end
    idle(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule